// File: doc/BRIEF.md
# Descriptor-Chained Single-Channel DMA Engine

This block is a single DMA channel that takes its work from a linked chain of descriptors held in memory. Software writes the address of the first descriptor into a pointer register and then sets the channel's start bit. From then on the engine runs without help. For each descriptor it reads five words into its live channel registers and copies the buffer that the descriptor names, one unit at a time. It then writes the control word back into the descriptor with a completion flag set, and follows the next pointer until the chain runs out.

All memory traffic uses one request port. A request carries a byte address, a transfer size, a write flag and a bus-layer select, and it stays up until the memory acknowledges it. Each side of a copy has its own unit width, its own address stepping and its own layer. The interrupt line is high while any completion flag is pending. Reading the status register returns the pending flags and clears them.

Top module: `ll_dma_engine`

## Requirements
- R1: After reset the start register (offset 0x00) reads 0, the status register (0x08) reads 0, the live source register (0x0C) reads 0, irq is low and mem_req is low.
- R2: Writing a value with bit 0 set to offset 0x00 starts the channel, and offset 0x00 bit 0 then reads 1 while the channel is busy. The engine reads five words, with size code 2, at base+0x0, +0x4, +0x8, +0xC and +0x10 in that order. The base is the pointer register (0x04) with its low two bits cleared, and the layer is the pointer's bits [1:0].
- R3: The fetched words load the live registers, which can be read back: source 0x0C, destination 0x10, control A 0x14, control B 0x18, next pointer 0x1C. After a buffer they show the stepped addresses and the written-back control A.
- R4: A buffer of control A[15:0] beats is copied. Each beat reads one source unit and then writes that value, zero-extended from the source width, as one destination unit. The widths are control A[17:16] for the source and [21:20] for the destination, coded 0 byte, 1 halfword, 2 word. The layers are control B[1:0] for the source and [5:4] for the destination.
- R5: Each side steps its address after every beat by its own unit size. Control B[9:8] sets the source mode and [13:12] the destination mode: 0 increments, 1 decrements, 2 or 3 holds the address fixed.
- R6: After the last beat of a buffer, the engine writes control A with bit 31 (done) set, as a word, to base+0xC on the descriptor's layer.
- R7: After the writeback, if control B bit 16 is set and the next pointer is non-zero, the engine loads the pointer register with the next pointer and fetches that descriptor. Otherwise the chain ends: bit 0 at 0x00 clears, and the pointer register keeps the last descriptor's pointer.
- R8: A buffer length of zero makes no data accesses. The writeback follows straight after the fifth descriptor word.
- R9: Status (0x08) bit 0 flags that a buffer finished and bit 1 that the chain ended. irq is high while either flag is set. A read returns both flags and clears them.
- R10: A completion event in the same cycle as a status read leaves its flag set after the read.
- R11: While the channel is busy, writes to the pointer register and to the start register have no effect.
- R12: While mem_req is high without mem_ack, the request and all of its fields stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Size code: 0 byte, 1 halfword, 2 word |
| mem_layer | output | LAYER_W | Bus-layer select |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Request completes at this edge |
| mem_rdata | input | 32 | Read data, right-aligned, valid with mem_ack |
| irq | output | 1 | Any completion flag pending |

## Verification
The status register can be cleared by a software read in the same cycle that the engine posts a buffer-done or chain-done event. The bench provokes this by holding the status read strobe high on every cycle of a whole chain while the memory acknowledges at once. Every event edge therefore lands on a read. The flags seen across all those reads are ORed, and both must appear; a clear that wins over a new event would lose the chain flag. A checker property also requires irq to be high in the cycle after any event.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    localparam int DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } st_e;

    // register offsets
    localparam logic [4:0] RG_START = 5'h00;
    localparam logic [4:0] RG_PTR   = 5'h04;
    localparam logic [4:0] RG_STAT  = 5'h08;
    localparam logic [4:0] RG_SRC   = 5'h0C;
    localparam logic [4:0] RG_DST   = 5'h10;
    localparam logic [4:0] RG_CTA   = 5'h14;
    localparam logic [4:0] RG_CTB   = 5'h18;
    localparam logic [4:0] RG_NXT   = 5'h1C;

    // control word fields
    localparam int CA_SW   = 16;
    localparam int CA_DW   = 20;
    localparam int CA_DONE = 31;
    localparam int CB_SL   = 0;
    localparam int CB_DL   = 4;
    localparam int CB_SM   = 8;
    localparam int CB_DM   = 12;
    localparam int CB_LINK = 16;

    localparam logic [1:0] AM_UP   = 2'd0;
    localparam logic [1:0] AM_DOWN = 2'd1;

    localparam logic [1:0] SZ_WORD = 2'd2;

    function automatic logic [2:0] unit_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] unit_mask(input logic [1:0] w);
        case (w)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/ll_dma_step.sv
module ll_dma_step
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        width_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] stride;

    always_comb begin
        stride = ADDR_W'(unit_bytes(width_i));
        case (mode_i)
            AM_UP:   addr_o = addr_i + stride;
            AM_DOWN: addr_o = addr_i - stride;
            default: addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/ll_dma_irq.sv
module ll_dma_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       buf_evt,
    input  logic       chain_evt,
    input  logic       rd_clr,
    output logic [1:0] status,
    output logic       irq
);

    typedef struct packed {
        logic [1:0] flags;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d = q;
        if (rd_clr) begin
            d.flags = 2'b00;
        end
        d.flags = d.flags | {chain_evt, buf_evt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status = q.flags;
    assign irq    = |q.flags;

endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int LAYER_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ptr_wr,
    input  logic [ADDR_W-1:0]  ptr_wdata,
    input  logic [ADDR_W-1:0]  src_step,
    input  logic [ADDR_W-1:0]  dst_step,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic               busy,
    output logic [ADDR_W-1:0]  ptr_q,
    output logic [ADDR_W-1:0]  src_q,
    output logic [ADDR_W-1:0]  dst_q,
    output logic [ADDR_W-1:0]  nxt_q,
    output logic [DW-1:0]      cta_q,
    output logic [DW-1:0]      ctb_q,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic [LAYER_W-1:0] mem_layer,
    output logic [DW-1:0]      mem_wdata,
    output logic               buf_evt,
    output logic               chain_evt
);

    localparam logic [2:0] LAST_WORD = 3'd4;

    typedef struct packed {
        st_e               st;
        logic [2:0]        idx;
        logic              busy;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] nxt;
        logic [DW-1:0]     cta;
        logic [DW-1:0]     ctb;
        logic [DW-1:0]     hold;
        logic [LEN_W-1:0]  cnt;
    } chan_t;

    chan_t q, d;

    logic [ADDR_W-1:0] dsc_base;
    logic [LEN_W-1:0]  blen;
    logic [LEN_W-1:0]  cnt_inc;
    logic [DW-1:0]     cta_done;

    always_comb begin
        dsc_base = {q.ptr[ADDR_W-1:2], 2'b00};
        blen     = q.cta[LEN_W-1:0];
        cnt_inc  = q.cnt + 1'b1;
        cta_done = q.cta | (DW'(1) << CA_DONE);

        d         = q;
        buf_evt   = 1'b0;
        chain_evt = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = SZ_WORD;
        mem_layer = '0;
        mem_wdata = '0;

        case (q.st)
            ST_IDLE: begin
                if (ptr_wr) begin
                    d.ptr = ptr_wdata;
                end
                if (start) begin
                    d.busy = 1'b1;
                    d.idx  = '0;
                    d.st   = ST_FETCH;
                end
            end

            ST_FETCH: begin
                mem_req   = 1'b1;
                mem_addr  = dsc_base + (ADDR_W'(q.idx) << 2);
                mem_layer = q.ptr[LAYER_W-1:0];
                if (mem_ack) begin
                    case (q.idx)
                        3'd0:    d.src = mem_rdata[ADDR_W-1:0];
                        3'd1:    d.dst = mem_rdata[ADDR_W-1:0];
                        3'd2:    d.nxt = mem_rdata[ADDR_W-1:0];
                        3'd3:    d.cta = mem_rdata;
                        default: d.ctb = mem_rdata;
                    endcase
                    if (q.idx == LAST_WORD) begin
                        d.cnt = '0;
                        d.st  = (blen == '0) ? ST_WBACK : ST_READ;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end

            ST_READ: begin
                mem_req   = 1'b1;
                mem_addr  = q.src;
                mem_size  = q.cta[CA_SW +: 2];
                mem_layer = q.ctb[CB_SL +: LAYER_W];
                if (mem_ack) begin
                    d.hold = mem_rdata & unit_mask(q.cta[CA_SW +: 2]);
                    d.st   = ST_WRITE;
                end
            end

            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.dst;
                mem_size  = q.cta[CA_DW +: 2];
                mem_layer = q.ctb[CB_DL +: LAYER_W];
                mem_wdata = q.hold;
                if (mem_ack) begin
                    d.src = src_step;
                    d.dst = dst_step;
                    d.cnt = cnt_inc;
                    d.st  = (cnt_inc == blen) ? ST_WBACK : ST_READ;
                end
            end

            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc_base + ADDR_W'(12);
                mem_layer = q.ptr[LAYER_W-1:0];
                mem_wdata = cta_done;
                if (mem_ack) begin
                    d.cta   = cta_done;
                    buf_evt = 1'b1;
                    if (!q.ctb[CB_LINK] || (q.nxt == '0)) begin
                        d.busy    = 1'b0;
                        d.st      = ST_IDLE;
                        chain_evt = 1'b1;
                    end else begin
                        d.ptr = q.nxt;
                        d.idx = '0;
                        d.st  = ST_FETCH;
                    end
                end
            end

            default: begin
                d.st   = ST_IDLE;
                d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy  = q.busy;
    assign ptr_q = q.ptr;
    assign src_q = q.src;
    assign dst_q = q.dst;
    assign nxt_q = q.nxt;
    assign cta_q = q.cta;
    assign ctb_q = q.ctb;

endmodule

// File: rtl/ll_dma_engine.sv
module ll_dma_engine
    import ll_dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int LAYER_W = 2,
    parameter int REG_AW  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic [LAYER_W-1:0] mem_layer,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               irq
);

    localparam int N_SIDES = 2;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_t;

    top_t q, d;

    logic              start;
    logic              ptr_wr;
    logic              rd_clr;
    logic              busy;
    logic              buf_evt;
    logic              chain_evt;
    logic [1:0]        status;
    logic [ADDR_W-1:0] ptr_q, src_q, dst_q, nxt_q;
    logic [DW-1:0]     cta_q, ctb_q;

    logic [ADDR_W-1:0] step_in  [N_SIDES];
    logic [ADDR_W-1:0] step_out [N_SIDES];
    logic [1:0]        step_w   [N_SIDES];
    logic [1:0]        step_m   [N_SIDES];

    assign start  = reg_wr && (reg_addr == RG_START) && reg_wdata[0];
    assign ptr_wr = reg_wr && (reg_addr == RG_PTR);
    assign rd_clr = reg_rd && (reg_addr == RG_STAT);

    assign step_in[0] = src_q;
    assign step_w[0]  = cta_q[CA_SW +: 2];
    assign step_m[0]  = ctb_q[CB_SM +: 2];
    assign step_in[1] = dst_q;
    assign step_w[1]  = cta_q[CA_DW +: 2];
    assign step_m[1]  = ctb_q[CB_DM +: 2];

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        ll_dma_step #(.ADDR_W(ADDR_W)) u_step (
            .addr_i  (step_in[g]),
            .width_i (step_w[g]),
            .mode_i  (step_m[g]),
            .addr_o  (step_out[g])
        );
    end

    ll_dma_chan #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .LAYER_W (LAYER_W)
    ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (reg_wdata[ADDR_W-1:0]),
        .src_step  (step_out[0]),
        .dst_step  (step_out[1]),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .ptr_q     (ptr_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .nxt_q     (nxt_q),
        .cta_q     (cta_q),
        .ctb_q     (ctb_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_layer (mem_layer),
        .mem_wdata (mem_wdata),
        .buf_evt   (buf_evt),
        .chain_evt (chain_evt)
    );

    ll_dma_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_evt   (buf_evt),
        .chain_evt (chain_evt),
        .rd_clr    (rd_clr),
        .status    (status),
        .irq       (irq)
    );

    always_comb begin
        d = q;
        if (reg_rd) begin
            case (reg_addr)
                RG_START: d.rdata = {{(DW-1){1'b0}}, busy};
                RG_PTR:   d.rdata = DW'(ptr_q);
                RG_STAT:  d.rdata = {{(DW-2){1'b0}}, status};
                RG_SRC:   d.rdata = DW'(src_q);
                RG_DST:   d.rdata = DW'(dst_q);
                RG_CTA:   d.rdata = cta_q;
                RG_CTB:   d.rdata = ctb_q;
                RG_NXT:   d.rdata = DW'(nxt_q);
                default:  d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = q.rdata;

endmodule

// File: rtl/ll_dma_engine_chk.sv
module ll_dma_engine_chk #(
    parameter int ADDR_W  = 32,
    parameter int LAYER_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [1:0]         mem_size,
    input logic [LAYER_W-1:0] mem_layer,
    input logic [31:0]        mem_wdata,
    input logic               irq,
    input logic               busy,
    input logic               buf_evt,
    input logic               chain_evt,
    input logic               rd_clr
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
            && $stable(mem_size) && $stable(mem_layer) && $stable(mem_wdata)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_chain_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_evt |-> (mem_req && mem_we && mem_ack && mem_wdata[31]));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !buf_evt && !chain_evt) |=> !irq);

    assert_event_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_evt || chain_evt) |=> irq);

endmodule

bind ll_dma_engine ll_dma_engine_chk #(
    .ADDR_W  (ADDR_W),
    .LAYER_W (LAYER_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_layer (mem_layer),
    .mem_wdata (mem_wdata),
    .irq       (irq),
    .busy      (busy),
    .buf_evt   (buf_evt),
    .chain_evt (chain_evt),
    .rd_clr    (rd_clr)
);

// File: tb/ll_dma_engine_bench.sv
`timescale 1ns/1ps
module ll_dma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [1:0]  mem_layer;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #10 clk = ~clk;

    ll_dma_engine u_ll_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_layer(mem_layer), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    logic [7:0]  mem    [0:4095];
    logic [7:0]  shadow [0:4095];
    logic [31:0] log_addr  [0:4095];
    logic [31:0] log_data  [0:4095];
    logic        log_we    [0:4095];
    logic [1:0]  log_layer [0:4095];
    int          log_n = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    int          hold_viol = 0;
    bit          stall_on = 1'b1;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mem_get(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = mem[(a + i) & 32'hFFF];
        return v;
    endfunction

    // memory model: acknowledge and data driven half a cycle away from the edge
    always @(negedge clk) begin
        if (pend && (!mem_req || mem_addr != pend_addr)) hold_viol++;
        mem_ack   = mem_req && (!stall_on || ($urandom % 3 != 0));
        mem_rdata = mem_get(mem_addr, mem_size);
        pend      = mem_req && !mem_ack;
        pend_addr = mem_addr;
    end

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we)
                for (int i = 0; i < nbytes(mem_size); i++)
                    mem[(mem_addr + i) & 32'hFFF] = mem_wdata[8*i +: 8];
            if (log_n < 4096) begin
                log_addr[log_n]  = mem_addr;
                log_data[log_n]  = mem_wdata;
                log_we[log_n]    = mem_we;
                log_layer[log_n] = mem_layer;
                log_n++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    function automatic logic [31:0] sh_get(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = shadow[(a + i) & 32'hFFF];
        return v;
    endfunction

    task automatic sh_put(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] v);
        for (int i = 0; i < nbytes(sz); i++) shadow[(a + i) & 32'hFFF] = v[8*i +: 8];
    endtask

    task automatic both_put(input logic [31:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            mem[(a + i) & 32'hFFF]    = v[8*i +: 8];
            shadow[(a + i) & 32'hFFF] = v[8*i +: 8];
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] w, input logic [1:0] m);
        if (m == 2'd0) return a + nbytes(w);
        if (m == 2'd1) return a - nbytes(w);
        return a;
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        int guard = 0;
        do begin
            rd(5'h00, v);
            guard++;
        end while (v[0] && guard < 5000);
    endtask

    task automatic run_chain(input int nd, input int pat, input bit zero_mid,
                             input bit null_end, input bit poke, input bit poll, input bit stall);
        logic [31:0] ptr[8], base[8], ca[8], cb[8], sa[8], da[8], nx[8];
        logic [31:0] v, acc, es, ed;
        logic [1:0]  ws, wd, ms, md;
        bit          lle;
        int          mark, bad, wbn, len;
        stall_on = stall;
        for (int k = 0; k < nd; k++) begin
            base[k] = 32'h10 + k * 32'h20;
            ptr[k]  = base[k] | ($urandom % 4);
        end
        for (int k = 0; k < nd; k++) begin
            if (pat == 1) begin
                ws = 2'(k % 3); wd = 2'((k + 1) % 3); ms = 2'(k % 3); md = 2'((k + 2) % 4); len = 3;
            end else begin
                ws = 2'($urandom % 3); wd = 2'($urandom % 3);
                ms = 2'($urandom % 4); md = 2'($urandom % 4); len = $urandom % 7;
            end
            if (zero_mid && k == 1) len = 0;
            lle   = (k < nd - 1) || null_end;
            nx[k] = (k < nd - 1) ? ptr[k+1] : (null_end ? 32'h0 : 32'h7F0);
            sa[k] = 32'h200 + ($urandom % 128) * 4;
            da[k] = 32'h900 + ($urandom % 128) * 4;
            ca[k] = 32'(len) | (32'(ws) << 16) | (32'(wd) << 20);
            cb[k] = 32'($urandom % 4) | (32'($urandom % 4) << 4) | (32'(ms) << 8)
                  | (32'(md) << 12) | (32'(lle) << 16);
            both_put(base[k] + 0,  sa[k]);
            both_put(base[k] + 4,  da[k]);
            both_put(base[k] + 8,  nx[k]);
            both_put(base[k] + 12, ca[k]);
            both_put(base[k] + 16, cb[k]);
        end
        // expected result of the whole chain
        for (int k = 0; k < nd; k++) begin
            es = sa[k]; ed = da[k];
            for (int b = 0; b < int'(ca[k][15:0]); b++) begin
                sh_put(ed, ca[k][21:20], sh_get(es, ca[k][17:16]));
                es = step(es, ca[k][17:16], cb[k][9:8]);
                ed = step(ed, ca[k][21:20], cb[k][13:12]);
            end
            sh_put(base[k] + 12, 2'd2, ca[k] | 32'h8000_0000);
        end
        rd(5'h08, v);
        mark = log_n;
        wr(5'h04, ptr[0]);
        wr(5'h00, 32'h1);
        if (poke) begin
            wr(5'h04, 32'h0BAD0);
            wr(5'h00, 32'h1);
            rd(5'h00, v);
            check("R11 busy reads 1", v, 32'h1);
        end
        if (poll) begin
            // R10: status read held on every cycle across the whole chain
            acc = '0;
            @(negedge clk); reg_rd = 1'b1; reg_addr = 5'h08;
            repeat (400) begin
                @(negedge clk);
                acc = acc | reg_rdata;
            end
            reg_rd = 1'b0;
            check("R10 flags survive same-cycle read", acc, 32'h3);
            rd(5'h08, v);
            check("R9 status empty after reads", v, 32'h0);
        end else begin
            wait_idle();
            rd(5'h08, v);
            check("R9 status pending", v, 32'h3);
            check("R9 irq low after read", 32'(irq), 32'h0);
            rd(5'h08, v);
            check("R9 status cleared", v, 32'h0);
        end
        rd(5'h00, v); check("R7 channel free at end", v, 32'h0);
        rd(5'h04, v); check("R7 R11 pointer holds last descriptor", v, ptr[nd-1]);
        rd(5'h0C, v); check("R3 R5 live source", v, es);
        rd(5'h10, v); check("R3 R5 live destination", v, ed);
        rd(5'h14, v); check("R3 live control A", v, ca[nd-1] | 32'h8000_0000);
        rd(5'h18, v); check("R3 live control B", v, cb[nd-1]);
        rd(5'h1C, v); check("R3 live next pointer", v, nx[nd-1]);
        bad = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== shadow[i]) bad++;
        check("R4 R5 R6 memory image", 32'(bad), 32'h0);
        bad = 0;
        for (int w = 0; w < 5; w++)
            if (log_addr[mark+w] != base[0] + 4*w || log_we[mark+w] || log_layer[mark+w] != ptr[0][1:0])
                bad++;
        check("R2 fetch order and layer", 32'(bad), 32'h0);
        bad = 0; wbn = 0;
        for (int i = mark; i < log_n; i++)
            if (log_we[i] && log_addr[i] < 32'h100) begin
                if (wbn >= nd || log_addr[i] != base[wbn] + 12 || log_layer[i] != ptr[wbn][1:0]
                    || log_data[i] != (ca[wbn] | 32'h8000_0000)) bad++;
                wbn++;
            end
        check("R6 writeback count", 32'(wbn), 32'(nd));
        check("R6 writeback address layer data", 32'(bad), 32'h0);
        if (zero_mid && nd > 1) begin
            bad = 1;
            for (int i = mark; i < log_n - 1; i++)
                if (!log_we[i] && log_addr[i] == base[1] + 16)
                    bad = (log_we[i+1] && log_addr[i+1] == base[1] + 12) ? 0 : 1;
            check("R8 zero length goes straight to writeback", 32'(bad), 32'h0);
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1357911));
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_req idle", 32'(mem_req), 32'h0);
        check("R1 irq low", 32'(irq), 32'h0);
        rd(5'h00, v); check("R1 start register", v, 32'h0);
        rd(5'h08, v); check("R1 status", v, 32'h0);
        rd(5'h0C, v); check("R1 live source", v, 32'h0);

        run_chain(3, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run_chain(2, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        run_chain(2, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_chain(1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int r = 0; r < 6; r++)
            run_chain(2 + ($urandom % 5), 0, 1'($urandom % 2), 1'($urandom % 2),
                      1'($urandom % 2), 1'b0, 1'($urandom % 2));

        check("R12 request held while unacknowledged", 32'(hold_viol), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule